// File: doc/BRIEF.md
# Round-Robin Warp Issue Scheduler

This block decides, every clock cycle, which group of threads (a warp) sends its next instruction into a shared SIMD pipeline. It holds, for each warp, a program counter, an active-thread mask and a lifecycle state. A warp is idle, ready, holding one instruction in the pipeline, or parked on an outstanding memory access. Only ready warps compete for the issue slot. They are picked fairly in rotation, and at most one warp issues per cycle.

A warp that has issued stays out of the ready pool until its instruction reports back. It rejoins the pool when the instruction completes without touching memory, or when memory returns the data a stalled instruction was waiting for. It goes back to idle if the completion says the warp has exited. Because a warp never has two instructions in flight, the pipeline needs no hazard checks between instructions of the same warp. A memory miss only parks the warp that missed, and all other ready warps keep issuing. Each issue carries the warp's PC and its active mask, so that lanes of disabled threads can suppress their writeback.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset every warp is idle and `issue_valid` is 0.
- R2: A launch aimed at an idle warp makes it ready. From the next cycle it is eligible, with the supplied start PC and active mask.
- R3: Among ready warps, the one issued is the first ready warp found scanning upward (wrapping) from a rotating pointer. After an issue the pointer moves to the warp above the one issued, with NUM_WARPS-1 wrapping to 0. After reset the pointer is 0.
- R4: At most one warp issues per cycle. An issued warp is not eligible again until a completion or memory return for it has been accepted.
- R5: `issue_pc` is the warp's current PC. Every issue advances that warp's PC by one, modulo 2^PC_W.
- R6: A memory-stall event for a warp with an instruction in flight parks that warp, and other ready warps keep issuing.
- R7: A memory-return event for a parked warp makes it ready again. Until that event arrives, the warp stays parked.
- R8: A completion for an in-flight warp makes it ready when `cmpl_last` is 0, and idle when `cmpl_last` is 1. An idle warp is never issued until it is launched again.
- R9: Events that do not match the target warp's state are ignored. These are a launch of a non-idle warp, a completion or stall for a warp with nothing in flight, and a return for a warp that is not parked.
- R10: When no warp is ready, `issue_valid` is 0 and the pointer does not move.
- R11: `issue_mask` is the active mask stored for the issued warp at its launch.
- R12: If a stall and a completion target the same in-flight warp in the same cycle, the stall takes effect and the warp is parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch a warp this cycle |
| launch_id | input | WID_W | Warp to launch |
| launch_pc | input | PC_W | Start PC of the launched warp |
| launch_mask | input | LANES | Active-thread mask of the launched warp |
| cmpl_valid | input | 1 | Non-memory completion this cycle |
| cmpl_id | input | WID_W | Warp whose instruction completed |
| cmpl_last | input | 1 | The completing instruction ends the warp |
| stall_valid | input | 1 | Memory miss this cycle |
| stall_id | input | WID_W | Warp that missed |
| mret_valid | input | 1 | Memory data returned this cycle |
| mret_id | input | WID_W | Warp whose data returned |
| issue_valid | output | 1 | A warp issues this cycle |
| issue_id | output | WID_W | Issuing warp |
| issue_pc | output | PC_W | PC of the issued instruction |
| issue_mask | output | LANES | Active mask sent with the issue |

## Verification
The bench builds the block with 8 warps, 16 lanes and a 12-bit PC. This keeps the rotation short, so the pointer wraps from the top warp to warp 0 many times during a run. A directed launch near the PC limit reaches the PC wraparound within a few issues. With 8 warps, random events aimed at random ids often land on warps in the wrong state, which exercises the ignore rules. Same-cycle stall and completion collisions on one warp also occur frequently.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

  typedef enum logic [1:0] {
    W_IDLE     = 2'd0,
    W_READY    = 2'd1,
    W_INFLIGHT = 2'd2,
    W_MEMWAIT  = 2'd3
  } wstate_t;

endpackage

// File: rtl/warp_slot.sv
module warp_slot
  import warp_sched_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int LANES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_hit,
  input  logic [PC_W-1:0]  launch_pc,
  input  logic [LANES-1:0] launch_mask,
  input  logic             issue_hit,
  input  logic             cmpl_hit,
  input  logic             cmpl_last,
  input  logic             stall_hit,
  input  logic             mret_hit,
  output wstate_t          state_o,
  output logic [PC_W-1:0]  pc_o,
  output logic [LANES-1:0] mask_o
);

  wstate_t          state_q, state_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic [LANES-1:0] mask_q, mask_d;

  function automatic logic [PC_W-1:0] pc_step(input logic [PC_W-1:0] pc);
    return pc + {{(PC_W-1){1'b0}}, 1'b1};
  endfunction

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    mask_d  = mask_q;
    unique case (state_q)
      W_IDLE: if (launch_hit) begin
        state_d = W_READY;
        pc_d    = launch_pc;
        mask_d  = launch_mask;
      end
      W_READY: if (issue_hit) begin
        state_d = W_INFLIGHT;
        pc_d    = pc_step(pc_q);
      end
      W_INFLIGHT: begin
        if (stall_hit)     state_d = W_MEMWAIT;
        else if (cmpl_hit) state_d = cmpl_last ? W_IDLE : W_READY;
      end
      W_MEMWAIT: if (mret_hit) state_d = W_READY;
      default: state_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      pc_q    <= '0;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      mask_q  <= mask_d;
    end
  end

  assign state_o = state_q;
  assign pc_o    = pc_q;
  assign mask_o  = mask_q;

  AST_MEMWAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == W_MEMWAIT && !mret_hit) |=> state_q == W_MEMWAIT)
    else $error("parked warp left wait without return"); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == W_IDLE && !launch_hit) |=> state_q == W_IDLE)
    else $error("idle warp woke without launch"); // R8

endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int N     = 32,
  parameter int WID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     ready_v,
  output logic             pick_valid,
  output logic [WID_W-1:0] pick_id
);

  logic [WID_W-1:0] ptr_q;
  logic [WID_W:0]   pick;

  // Returns {found, index} of the first set bit at or above base, wrapping.
  function automatic logic [WID_W:0] rr_scan(input logic [N-1:0] rdy,
                                             input logic [WID_W-1:0] base);
    logic [WID_W:0] r;
    int idx;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      idx = (int'(base) + i) % N;
      if (rdy[idx]) r = {1'b1, WID_W'(idx)};
    end
    return r;
  endfunction

  function automatic logic [WID_W-1:0] after(input logic [WID_W-1:0] id);
    return (int'(id) == N - 1) ? '0 : id + 1'b1;
  endfunction

  assign pick       = rr_scan(ready_v, ptr_q);
  assign pick_valid = pick[WID_W];
  assign pick_id    = pick[WID_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)          ptr_q <= '0;
    else if (pick_valid) ptr_q <= after(pick_id);
  end

  AST_EMPTY_NO_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_v == '0) |-> !pick_valid)
    else $error("pick with empty ready pool"); // R10

  AST_PTR_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_valid |=> $stable(ptr_q))
    else $error("pointer moved without issue"); // R10

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 32,
  parameter int PC_W      = 32,
  parameter int LANES     = 32,
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_valid,
  input  logic [WID_W-1:0] launch_id,
  input  logic [PC_W-1:0]  launch_pc,
  input  logic [LANES-1:0] launch_mask,
  input  logic             cmpl_valid,
  input  logic [WID_W-1:0] cmpl_id,
  input  logic             cmpl_last,
  input  logic             stall_valid,
  input  logic [WID_W-1:0] stall_id,
  input  logic             mret_valid,
  input  logic [WID_W-1:0] mret_id,
  output logic             issue_valid,
  output logic [WID_W-1:0] issue_id,
  output logic [PC_W-1:0]  issue_pc,
  output logic [LANES-1:0] issue_mask
);

  wstate_t          slot_state [NUM_WARPS];
  logic [PC_W-1:0]  slot_pc    [NUM_WARPS];
  logic [LANES-1:0] slot_mask  [NUM_WARPS];
  logic [NUM_WARPS-1:0] ready_v;
  logic [NUM_WARPS-1:0] launch_hit_v, issue_hit_v, cmpl_hit_v, stall_hit_v, mret_hit_v;
  logic             pick_valid;
  logic [WID_W-1:0] pick_id;

  function automatic logic targets(input logic v, input logic [WID_W-1:0] id, input int w);
    return v && (int'(id) == w);
  endfunction

  generate
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
      assign launch_hit_v[w] = targets(launch_valid, launch_id, w);
      assign issue_hit_v[w]  = targets(pick_valid,   pick_id,   w);
      assign cmpl_hit_v[w]   = targets(cmpl_valid,   cmpl_id,   w);
      assign stall_hit_v[w]  = targets(stall_valid,  stall_id,  w);
      assign mret_hit_v[w]   = targets(mret_valid,   mret_id,   w);
      assign ready_v[w]      = (slot_state[w] == W_READY);

      warp_slot #(.PC_W(PC_W), .LANES(LANES)) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_hit  (launch_hit_v[w]),
        .launch_pc   (launch_pc),
        .launch_mask (launch_mask),
        .issue_hit   (issue_hit_v[w]),
        .cmpl_hit    (cmpl_hit_v[w]),
        .cmpl_last   (cmpl_last),
        .stall_hit   (stall_hit_v[w]),
        .mret_hit    (mret_hit_v[w]),
        .state_o     (slot_state[w]),
        .pc_o        (slot_pc[w]),
        .mask_o      (slot_mask[w])
      );
    end
  endgenerate

  rr_picker #(.N(NUM_WARPS), .WID_W(WID_W)) u_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready_v    (ready_v),
    .pick_valid (pick_valid),
    .pick_id    (pick_id)
  );

  assign issue_valid = pick_valid;
  assign issue_id    = pick_valid ? pick_id : '0;
  assign issue_pc    = pick_valid ? slot_pc[pick_id] : '0;
  assign issue_mask  = pick_valid ? slot_mask[pick_id] : '0;

  AST_ISSUE_FROM_READY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> slot_state[issue_id] == W_READY)
    else $error("issued warp was not ready"); // R4

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> !(issue_valid && issue_id == $past(issue_id)))
    else $error("warp issued twice in a row"); // R4

  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> slot_pc[$past(issue_id)] == $past(issue_pc) + 1'b1)
    else $error("PC did not step after issue"); // R5

endmodule

// File: tb/warp_issue_sched_bench.sv
module warp_issue_sched_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam int PW = 12;
  localparam int LW = 16;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          launch_valid = 0, cmpl_valid = 0, cmpl_last = 0, stall_valid = 0, mret_valid = 0;
  logic [IW-1:0] launch_id = '0, cmpl_id = '0, stall_id = '0, mret_id = '0;
  logic [PW-1:0] launch_pc = '0;
  logic [LW-1:0] launch_mask = '0;
  logic          issue_valid;
  logic [IW-1:0] issue_id;
  logic [PW-1:0] issue_pc;
  logic [LW-1:0] issue_mask;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  int            m_st   [NW];
  logic [PW-1:0] m_pc   [NW];
  logic [LW-1:0] m_mask [NW];
  int            m_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(NW), .PC_W(PW), .LANES(LW)) u_warp_issue_sched (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(launch_valid), .launch_id(launch_id), .launch_pc(launch_pc), .launch_mask(launch_mask),
    .cmpl_valid(cmpl_valid), .cmpl_id(cmpl_id), .cmpl_last(cmpl_last),
    .stall_valid(stall_valid), .stall_id(stall_id),
    .mret_valid(mret_valid), .mret_id(mret_id),
    .issue_valid(issue_valid), .issue_id(issue_id), .issue_pc(issue_pc), .issue_mask(issue_mask)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One cycle: compare outputs at negedge against model, drive events, advance model.
  task automatic step(string tag,
                      bit lv, int lid, logic [PW-1:0] lpc, logic [LW-1:0] lmask,
                      bit cv, int cid, bit clast, bit sv, int sid, bit mv, int mid);
    bit ev = 0;
    int eid = 0;
    for (int i = 0; i < NW; i++) begin
      int idx = (m_ptr + i) % NW;
      if (!ev && m_st[idx] == 1) begin ev = 1; eid = idx; end
    end
    check(tag, "issue_valid", 32'(issue_valid), 32'(ev));
    if (ev) begin
      check(tag, "issue_id", 32'(issue_id), 32'(eid));
      check(tag, "issue_pc (R5)", 32'(issue_pc), 32'(m_pc[eid]));
      check(tag, "issue_mask (R11)", 32'(issue_mask), 32'(m_mask[eid]));
    end
    launch_valid = lv; launch_id = IW'(lid); launch_pc = lpc; launch_mask = lmask;
    cmpl_valid = cv; cmpl_id = IW'(cid); cmpl_last = clast;
    stall_valid = sv; stall_id = IW'(sid);
    mret_valid = mv; mret_id = IW'(mid);
    for (int w = 0; w < NW; w++) begin
      case (m_st[w])
        0: if (lv && lid == w) begin m_st[w] = 1; m_pc[w] = lpc; m_mask[w] = lmask; end
        1: if (ev && eid == w) begin m_st[w] = 2; m_pc[w] = m_pc[w] + 1'b1; end
        2: if (sv && sid == w) m_st[w] = 3;
           else if (cv && cid == w) m_st[w] = clast ? 0 : 1;
        default: if (mv && mid == w) m_st[w] = 1;
      endcase
    end
    if (ev) m_ptr = (eid + 1) % NW;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, '0, '0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int w = 0; w < NW; w++) begin m_st[w] = 0; m_pc[w] = '0; m_mask[w] = '0; end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    idle("R1");                                             // nothing ready after reset
    step("R2", 1, 3, 12'hFFE, 16'hA5A5, 0,0,0, 0,0, 0,0);   // launch warp 3
    idle("R2");                                             // warp 3 issues at FFE
    step("R9", 1, 3, 12'h100, 16'h0001, 0,0,0, 0,0, 0,0);   // relaunch of busy warp ignored
    idle("R4");                                             // in flight: no reissue
    step("R8", 0,0,'0,'0, 1, 3, 0, 0,0, 0,0);               // completion, back to ready
    idle("R5");                                             // issue at FFF
    step("R5", 0,0,'0,'0, 1, 3, 0, 0,0, 0,0);
    idle("R5");                                             // issue at 000 (wrap)
    step("R6", 1, 5, 12'h040, 16'hFFFF, 0,0,0, 1, 3, 0,0);  // warp 3 misses, warp 5 launches
    idle("R6");                                             // warp 5 issues while 3 parked
    step("R12", 0,0,'0,'0, 1, 5, 0, 1, 5, 0,0);             // stall wins over completion
    step("R9", 0,0,'0,'0, 1, 5, 0, 0,0, 0,0);               // completion of parked warp ignored
    step("R7", 0,0,'0,'0, 0,0,0, 0,0, 1, 3);                // return for warp 3
    step("R7", 0,0,'0,'0, 0,0,0, 0,0, 1, 5);                // return for warp 5
    idle("R3");
    step("R3", 0,0,'0,'0, 1, 3, 1, 0,0, 0,0);               // warp 3 exits
    step("R8", 0,0,'0,'0, 1, 5, 1, 0,0, 1, 3);              // warp 5 exits; return to idle warp ignored
    idle("R10");
    idle("R10");

    for (int c = 0; c < 4000; c++) begin
      int lid = $urandom % NW, cid = $urandom % NW, sid = $urandom % NW, mid = $urandom % NW;
      repeat (4) if (m_st[lid] != 0) lid = $urandom % NW;
      repeat (4) if (m_st[cid] != 2) cid = $urandom % NW;
      repeat (4) if (m_st[sid] != 2) sid = $urandom % NW;
      repeat (4) if (m_st[mid] != 3) mid = $urandom % NW;
      step("R3", ($urandom % 3) == 0, lid, PW'($urandom), LW'($urandom),
           ($urandom % 2) == 0, cid, ($urandom % 8) == 0,
           ($urandom % 4) == 0, sid, ($urandom % 2) == 0, mid);
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule